// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Butterfly Array

This block performs the path-metric update of one Viterbi trellis step. A butterfly takes two old path metrics, M1 and M2, and one signed branch metric d. It forms two survivors. The first is the larger of M1+d and M2-d. The second is the larger of M1-d and M2+d. The two competing candidates for each survivor carry the branch metric with opposite signs, so a single value of d is enough for the whole butterfly. Each comparison also yields one decision bit, which a traceback stage downstream can store.

The trellis has 32 states and therefore 16 butterflies per step. Four butterfly lanes run in parallel, so one step takes four cycles, handling one group of four butterflies per cycle. The path metrics are held in two banks. A step reads the current bank and writes the other, and the two banks swap roles when the step completes.

The caller loads the 16 branch metrics and pulses a start strobe. It then collects the new metrics and decisions of each group as they appear, and waits for the done strobe. A read port exposes the current bank at any time.

Top module: `vit_acs_array`

## Requirements
- R1: The first survivor of butterfly j is M1+d when (M1+d)-(M2-d) is strictly positive in the modular sense, and M2-d otherwise. M1 is old state 2j and M2 is old state 2j+1. The first survivor becomes new state j.
- R2: The second survivor of butterfly j is M1-d when (M1-d)-(M2+d) is strictly positive in the modular sense, and M2+d otherwise. The second survivor becomes new state j+16.
- R3: When the two candidates of a comparison are equal, the second candidate (the one built from M2) is chosen.
- R4: Each comparison emits a decision bit that is 1 when the M2-based candidate won and 0 when the M1-based candidate won.
- R5: Metrics are 12-bit unsigned values that wrap around. The branch metric d is a signed 6-bit two's-complement value. The comparison "a > b" is true when the 12-bit difference a-b is nonzero and its top bit is 0, so ordering stays correct across a wrap.
- R6: When start is accepted at an edge, the next four edges each present one group g (0 to 3) on the outputs, with pm_vld high and pm_grp equal to g. Lane l carries butterfly 4g+l. In pm_o, lane l holds its first survivor at bits [24l+11:24l] and its second at [24l+23:24l+12]. In dec_o, bit 2l is lane l's first decision and bit 2l+1 its second. done is high for exactly one cycle, together with group 3.
- R7: start is ignored while a step is running. A change on bm_i after start has been accepted does not affect the running step.
- R8: The read port shows the old metrics for the whole duration of a step. From the cycle in which done is high, it shows the new metrics.
- R9: After reset, state 0 holds metric 0 and every other state holds 1024. The outputs are idle: pm_vld, busy and done are all 0.
- R10: In bm_i, the branch metric of butterfly j occupies bits [6j+5:6j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one trellis step (accepted only when idle) |
| bm_i | input | 96 | Sixteen signed 6-bit branch metrics, butterfly j at [6j+5:6j] |
| rd_addr_i | input | 5 | State index for the metric read port |
| rd_data_o | output | 12 | Current metric of state rd_addr_i |
| pm_vld_o | output | 1 | pm_o and dec_o carry a group's results |
| pm_grp_o | output | 2 | Index of the group on pm_o |
| pm_o | output | 96 | New metrics of the four lanes |
| dec_o | output | 8 | Decision bits of the four lanes |
| busy_o | output | 1 | A step is running |
| done_o | output | 1 | One-cycle pulse when a step completes |

## Verification
A wrong selection or a wrong sign on d shows up on pm_o and dec_o in the very cycle the affected group is presented. It also persists into the banked metrics, so every later step reads a diverging value. A bank-select or address fault leaves pm_o correct for the current step but corrupts the read port once done is high. Such a fault therefore surfaces at the readback after the step, or in the first group of the next step. Long random runs carry the metrics through several wraps of the 12-bit range, which exposes a comparison that ignores the modular order.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_e;

  localparam int DEF_METRIC_W = 12;
  localparam int DEF_BM_W     = 6;

endpackage

// File: rtl/acs_bf.sv
module acs_bf #(
  parameter int MW = 12,
  parameter int DW = 6
) (
  input  logic [MW-1:0] m1_i,
  input  logic [MW-1:0] m2_i,
  input  logic [DW-1:0] d_i,
  output logic [MW-1:0] surv_a_o,
  output logic [MW-1:0] surv_b_o,
  output logic          dec_a_o,
  output logic          dec_b_o
);

  logic [MW-1:0] d_ext;
  logic [MW-1:0] cand_a1, cand_a2, cand_b1, cand_b2;
  logic [MW-1:0] diff_a, diff_b;
  logic          a1_wins, b1_wins;

  always_comb begin
    d_ext   = {{(MW-DW){d_i[DW-1]}}, d_i};
    cand_a1 = m1_i + d_ext;
    cand_a2 = m2_i - d_ext;
    cand_b1 = m1_i - d_ext;
    cand_b2 = m2_i + d_ext;
    diff_a  = cand_a1 - cand_a2;
    diff_b  = cand_b1 - cand_b2;
    a1_wins = (diff_a != '0) && !diff_a[MW-1];
    b1_wins = (diff_b != '0) && !diff_b[MW-1];
    dec_a_o  = !a1_wins;
    dec_b_o  = !b1_wins;
    surv_a_o = a1_wins ? cand_a1 : cand_a2;
    surv_b_o = b1_wins ? cand_b1 : cand_b2;
  end

  // R3: equal candidates must resolve toward the M2-based candidate
  always_comb begin
    a_r3_tie_second_a: assert (!(cand_a1 == cand_a2) || (dec_a_o && surv_a_o == cand_a2));
    a_r3_tie_second_b: assert (!(cand_b1 == cand_b2) || (dec_b_o && surv_b_o == cand_b2));
  end

endmodule

// File: rtl/acs_lanes.sv
module acs_lanes #(
  parameter int LANES = 4,
  parameter int MW    = 12,
  parameter int DW    = 6
) (
  input  logic [LANES*MW-1:0] m1_i,
  input  logic [LANES*MW-1:0] m2_i,
  input  logic [LANES*DW-1:0] d_i,
  output logic [LANES*MW-1:0] surv_a_o,
  output logic [LANES*MW-1:0] surv_b_o,
  output logic [LANES-1:0]    dec_a_o,
  output logic [LANES-1:0]    dec_b_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    acs_bf #(.MW(MW), .DW(DW)) u_bf (
      .m1_i    (m1_i[l*MW +: MW]),
      .m2_i    (m2_i[l*MW +: MW]),
      .d_i     (d_i[l*DW +: DW]),
      .surv_a_o(surv_a_o[l*MW +: MW]),
      .surv_b_o(surv_b_o[l*MW +: MW]),
      .dec_a_o (dec_a_o[l]),
      .dec_b_o (dec_b_o[l])
    );
  end

endmodule

// File: rtl/metric_store.sv
module metric_store #(
  parameter int NS         = 32,
  parameter int LANES      = 4,
  parameter int MW         = 12,
  parameter int INIT_LARGE = 1024,
  localparam int AW        = $clog2(NS),
  localparam int NBF       = NS / 2,
  localparam int GROUPS    = NBF / LANES,
  localparam int GW        = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GW-1:0]       grp_i,
  input  logic                wr_en_i,
  input  logic                flip_i,
  input  logic [LANES*MW-1:0] new_a_i,
  input  logic [LANES*MW-1:0] new_b_i,
  output logic [LANES*MW-1:0] old_a_o,
  output logic [LANES*MW-1:0] old_b_o,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [MW-1:0]       rd_data_o
);

  logic [MW-1:0] bank_q [2][NS];
  logic          sel_q;
  logic          sel_d;
  logic [AW-1:0] ra_idx [LANES];
  logic [AW-1:0] rb_idx [LANES];
  logic [AW-1:0] wa_idx [LANES];
  logic [AW-1:0] wb_idx [LANES];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      ra_idx[l] = AW'(2 * (int'(grp_i) * LANES + l));
      rb_idx[l] = AW'(2 * (int'(grp_i) * LANES + l) + 1);
      wa_idx[l] = AW'(int'(grp_i) * LANES + l);
      wb_idx[l] = AW'(int'(grp_i) * LANES + l + NBF);
      old_a_o[l*MW +: MW] = bank_q[sel_q][ra_idx[l]];
      old_b_o[l*MW +: MW] = bank_q[sel_q][rb_idx[l]];
    end
    rd_data_o = bank_q[sel_q][rd_addr_i];
    sel_d     = flip_i ? !sel_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        for (int s = 0; s < NS; s++) begin
          bank_q[b][s] <= (s == 0) ? '0 : MW'(INIT_LARGE);
        end
      end
    end else begin
      sel_q <= sel_d;
      if (wr_en_i) begin
        for (int l = 0; l < LANES; l++) begin
          bank_q[!sel_q][wa_idx[l]] <= new_a_i[l*MW +: MW];
          bank_q[!sel_q][wb_idx[l]] <= new_b_i[l*MW +: MW];
        end
      end
    end
  end

  // R8: the end of a step always swaps the banks
  a_r8_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    flip_i |=> (sel_q != $past(sel_q)));

  // R8: no swap without the end of a step
  a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_i |=> $stable(sel_q));

endmodule

// File: rtl/vit_acs_array.sv
module vit_acs_array
  import vit_acs_pkg::*;
#(
  parameter int NUM_STATES = 32,
  parameter int LANES      = 4,
  parameter int MW         = DEF_METRIC_W,
  parameter int DW         = DEF_BM_W,
  parameter int INIT_LARGE = 1024,
  localparam int NBF       = NUM_STATES / 2,
  localparam int GROUPS    = NBF / LANES,
  localparam int GW        = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int AW        = $clog2(NUM_STATES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [NBF*DW-1:0]     bm_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [MW-1:0]         rd_data_o,
  output logic                  pm_vld_o,
  output logic [GW-1:0]         pm_grp_o,
  output logic [LANES*2*MW-1:0] pm_o,
  output logic [LANES*2-1:0]    dec_o,
  output logic                  busy_o,
  output logic                  done_o
);

  localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

  seq_e                    state_q, state_d;
  logic [GW-1:0]           grp_q, grp_d;
  logic [NBF*DW-1:0]       bm_q, bm_d;
  logic                    bm_en;
  logic                    vld_q, vld_d;
  logic [GW-1:0]           idx_q, idx_d;
  logic [LANES*2*MW-1:0]   pm_q, pm_d;
  logic [LANES*2-1:0]      dec_q, dec_d;
  logic                    done_q, done_d;
  logic                    running, last_grp;

  logic [LANES*MW-1:0]     old_a, old_b, surv_a, surv_b;
  logic [LANES*DW-1:0]     lane_d;
  logic [LANES-1:0]        dec_a, dec_b;

  assign running  = (state_q == SEQ_RUN);
  assign last_grp = running && (grp_q == LAST_GRP);

  for (genvar l = 0; l < LANES; l++) begin : g_bm
    assign lane_d[l*DW +: DW] = bm_q[(int'(grp_q) * LANES + l) * DW +: DW];
  end

  metric_store #(
    .NS(NUM_STATES), .LANES(LANES), .MW(MW), .INIT_LARGE(INIT_LARGE)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_i    (grp_q),
    .wr_en_i  (running),
    .flip_i   (last_grp),
    .new_a_i  (surv_a),
    .new_b_i  (surv_b),
    .old_a_o  (old_a),
    .old_b_o  (old_b),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );

  acs_lanes #(.LANES(LANES), .MW(MW), .DW(DW)) u_lanes (
    .m1_i    (old_a),
    .m2_i    (old_b),
    .d_i     (lane_d),
    .surv_a_o(surv_a),
    .surv_b_o(surv_b),
    .dec_a_o (dec_a),
    .dec_b_o (dec_b)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    grp_d   = grp_q;
    bm_d    = bm_q;
    bm_en   = 1'b0;
    if (!running) begin
      if (start_i) begin
        state_d = SEQ_RUN;
        grp_d   = '0;
        bm_d    = bm_i;
        bm_en   = 1'b1;
      end
    end else begin
      grp_d = grp_q + 1'b1;
      if (grp_q == LAST_GRP) state_d = SEQ_IDLE;
    end

    vld_d  = running;
    idx_d  = running ? grp_q : idx_q;
    done_d = last_grp;
    pm_d   = pm_q;
    dec_d  = dec_q;
    if (running) begin
      for (int l = 0; l < LANES; l++) begin
        pm_d[2*MW*l +: MW]      = surv_a[l*MW +: MW];
        pm_d[2*MW*l + MW +: MW] = surv_b[l*MW +: MW];
        dec_d[2*l]              = dec_a[l];
        dec_d[2*l+1]            = dec_b[l];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      grp_q   <= '0;
      bm_q    <= '0;
      vld_q   <= 1'b0;
      idx_q   <= '0;
      pm_q    <= '0;
      dec_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      grp_q   <= grp_d;
      if (bm_en) bm_q <= bm_d;
      vld_q   <= vld_d;
      idx_q   <= idx_d;
      pm_q    <= pm_d;
      dec_q   <= dec_d;
      done_q  <= done_d;
    end
  end

  assign pm_vld_o = vld_q;
  assign pm_grp_o = idx_q;
  assign pm_o     = pm_q;
  assign dec_o    = dec_q;
  assign busy_o   = running;
  assign done_o   = done_q;

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: done coincides with the last group on the outputs
  a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pm_vld_o && pm_grp_o == LAST_GRP));

  // R6: groups follow one another without gaps
  a_r6_group_order: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_vld_o && pm_grp_o != LAST_GRP) |=> (pm_vld_o && pm_grp_o == $past(pm_grp_o) + 1'b1));

  // R7: branch metrics are frozen while a step is in flight
  a_r7_bm_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_grp) |=> $stable(bm_q));

endmodule

// File: tb/tb_vit_acs_array.sv
module tb_vit_acs_array;

  localparam int NS  = 32;
  localparam int NBF = 16;
  localparam int L   = 4;
  localparam int MW  = 12;
  localparam int DW  = 6;
  localparam int MASK = 4095;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [NBF*DW-1:0] bm_i;
  logic [4:0]        rd_addr_i;
  logic [MW-1:0]     rd_data_o;
  logic              pm_vld_o;
  logic [1:0]        pm_grp_o;
  logic [L*2*MW-1:0] pm_o;
  logic [L*2-1:0]    dec_o;
  logic              busy_o;
  logic              done_o;

  int checks = 0;
  int errors = 0;
  int mdl [NS];
  bit finished = 1'b0;

  vit_acs_array dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bm_i(bm_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .pm_vld_o(pm_vld_o),
    .pm_grp_o(pm_grp_o), .pm_o(pm_o), .dec_o(dec_o), .busy_o(busy_o),
    .done_o(done_o)
  );

  always #10 clk = ~clk;

  function automatic bit mod_gt(int a, int b);
    int df;
    df = (a - b) & MASK;
    return (df != 0) && (df < 2048);
  endfunction

  function automatic int bm_of(logic [NBF*DW-1:0] v, int j);
    logic [DW-1:0] raw;
    raw = v[j*DW +: DW];
    return int'($signed(raw));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic readback(string req);
    for (int s = 0; s < NS; s++) begin
      rd_addr_i = 5'(s);
      #1;
      chk(req, int'(rd_data_o), mdl[s]);
    end
  endtask

  task automatic run_step(logic [NBF*DW-1:0] v, bit poke);
    int nxt [NS];
    int m1, m2, d, a1, a2, b1, b2, ea, eb;
    bit da, db;
    @(negedge clk);
    bm_i = v;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      start_i = 1'b1;                   // R7: ignored while running
      bm_i = {$urandom, $urandom, $urandom};
    end
    for (int g = 0; g < 4; g++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk("R6 vld", int'(pm_vld_o), 1);
      chk("R6 grp", int'(pm_grp_o), g);
      chk("R6 done", int'(done_o), (g == 3) ? 1 : 0);
      if (g == 1) begin
        rd_addr_i = 5'(NBF + 3);
        #1;
        chk("R8 old during step", int'(rd_data_o), mdl[NBF + 3]);
      end
      for (int l = 0; l < L; l++) begin
        int j;
        j  = g * L + l;
        m1 = mdl[2*j];
        m2 = mdl[2*j+1];
        d  = bm_of(v, j);
        a1 = (m1 + d) & MASK;  a2 = (m2 - d) & MASK;
        b1 = (m1 - d) & MASK;  b2 = (m2 + d) & MASK;
        da = !mod_gt(a1, a2);  db = !mod_gt(b1, b2);
        ea = da ? a2 : a1;     eb = db ? b2 : b1;
        nxt[j] = ea;
        nxt[j + NBF] = eb;
        chk("R1 first survivor", int'(pm_o[2*MW*l +: MW]), ea);
        chk("R2 second survivor", int'(pm_o[2*MW*l + MW +: MW]), eb);
        chk("R4 first decision", int'(dec_o[2*l]), int'(da));
        chk("R4 second decision", int'(dec_o[2*l+1]), int'(db));
      end
    end
    for (int s = 0; s < NS; s++) mdl[s] = nxt[s];
    readback("R8 new after done");
    @(negedge clk);
    chk("R6 done pulse", int'(done_o), 0);
    chk("R6 vld drop", int'(pm_vld_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NBF*DW-1:0] v;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    start_i = 1'b0;
    bm_i = '0;
    rd_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < NS; s++) mdl[s] = (s == 0) ? 0 : 1024;
    chk("R9 busy", int'(busy_o), 0);
    chk("R9 done", int'(done_o), 0);
    chk("R9 vld", int'(pm_vld_o), 0);
    readback("R9 reset metrics");

    // R3: d = 0 gives equal candidates in butterflies 1..15
    run_step('0, 1'b0);

    // R5, R10: extreme branch metrics, alternating sign per butterfly
    for (int j = 0; j < NBF; j++) v[j*DW +: DW] = (j % 2 == 0) ? 6'h1F : 6'h20;
    run_step(v, 1'b1);

    // R3: symmetric ties with mixed metrics
    for (int j = 0; j < NBF; j++) v[j*DW +: DW] = 6'(j);
    run_step(v, 1'b0);

    // R5: random steps long enough to wrap the metric range
    for (int n = 0; n < 250; n++) begin
      v = {$urandom, $urandom, $urandom};
      run_step(v, (n % 3) == 0);
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule